// File: doc/BRIEF.md
# Temperature Conversion Scheduler

This block decides when a two-channel temperature converter runs. In normal operation it launches one conversion pair at the start of every measurement period. A pair converts the local channel first and then the remote channel. The period is a base number of time-base ticks, scaled by a power of two that a 3-bit rate code selects. The block pulses a start strobe to the converter along with a channel select. It waits for that channel's done pulse, then raises a one-cycle write strobe for the matching value register. It drives a BUSY bit while a pair is in flight.

Standby has two sources: an active-low standby pin and a software stop bit in the configuration register. No periodic conversions run in either kind of standby, and the value registers receive no write strobes. In software standby with the pin high, a one-shot request runs one pair and the block then returns to standby. In pin standby, one-shot requests are ignored. When standby is entered while a conversion is in flight, the conversion is cut short and its result is discarded. When standby ends, a pair starts at once.

Top module: `conv_sched`

## Requirements
- R1: The launch period is BASE_TICKS * 2^(7-c) tick pulses, where c is rate bits [2:0]. Code 7 is the shortest period and code 0 is 128 times longer. Launches in normal operation are spaced exactly one period apart.
- R2: A rate value with any of bits [7:3] set behaves as code 7, whatever its low bits are.
- R3: A pair converts local first (conv_chan_o = 0) and then remote (conv_chan_o = 1), with conv_start_o a one-cycle pulse for each conversion. After reset in normal operation, the first local start is high in the first cycle after reset is released.
- R4: busy_o is 0 in reset and while idle. It rises in the cycle that carries the local start pulse and stays 1 until the cycle that carries the remote write strobe.
- R5: local_we_o (remote_we_o) pulses for one cycle, in the cycle after conv_done_i[0] (conv_done_i[1]) is sampled while the local (remote) conversion is in flight. A done bit for the channel not being converted has no effect.
- R6: Standby holds while stby_n_i = 0 or cfg_stop_i = 1. In standby no periodic pair starts and no write strobe fires.
- R7: When standby is entered during a periodic pair, busy_o drops in the next cycle. That conversion raises no write strobe, even if its done arrives in the same cycle or later.
- R8: With cfg_stop_i = 1 and stby_n_i = 1, a one-shot pulse while idle runs exactly one pair with both write strobes, then the block stays idle.
- R9: While stby_n_i = 0, a one-shot pulse starts nothing.
- R10: In normal operation a one-shot pulse starts nothing beyond the periodic schedule.
- R11: When standby ends, the local start pulse appears in the cycle after the one in which the standby condition cleared.
- R12: When the pin goes low during a one-shot pair, busy_o drops in the next cycle and that conversion raises no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Time-base pulse, one cycle wide |
| rate_i | input | 8 | Conversion rate register value |
| cfg_stop_i | input | 1 | Configuration stop bit (1 = software standby) |
| stby_n_i | input | 1 | Standby pin (0 = standby) |
| oneshot_i | input | 1 | One-shot request strobe |
| conv_done_i | input | 2 | Converter done, bit 0 local, bit 1 remote |
| conv_start_o | output | 1 | Converter start pulse |
| conv_chan_o | output | 1 | Channel select, 0 local, 1 remote |
| busy_o | output | 1 | BUSY status bit |
| local_we_o | output | 1 | Local value register write strobe |
| remote_we_o | output | 1 | Remote value register write strobe |

## Verification
Several rules are checked on every cycle by assertions:
- start pulses fall only inside busy windows;
- the two write strobes never overlap;
- an abort leaves busy low and no strobe in the next cycle;
- no start follows a cycle with the pin low;
- due is raised only by a tick or by standby hold.

The bench scenarios show:
- the exact launch spacing for each rate code, including reserved codes;
- the local-then-remote order;
- how one-shots are handled in each mode;
- that a done arriving together with, or after, an abort never reaches a value register.

// File: rtl/conv_sched_pkg.sv
// Shared types for the conversion scheduler.
// Assumes two channels: index 0 local, index 1 remote.
package conv_sched_pkg;
    localparam int NUM_CH = 2;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOCAL  = 2'd1,
        ST_REMOTE = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_RUN       = 2'd0,
        MODE_SOFT_STBY = 2'd1,
        MODE_PIN_STBY  = 2'd2
    } op_mode_t;
endpackage

// File: rtl/cs_mode_ctrl.sv
// Operating mode decode. Pin standby takes priority over the software stop bit.
// Assumes both inputs are already synchronous to clk.
module cs_mode_ctrl
    import conv_sched_pkg::*;
(
    input  logic     cfg_stop_i,
    input  logic     stby_n_i,
    output op_mode_t mode_o
);
    // Purpose: map the pin and config bit onto one of three modes.
    always_comb begin
        if (!stby_n_i)
            mode_o = MODE_PIN_STBY;
        else if (cfg_stop_i)
            mode_o = MODE_SOFT_STBY;
        else
            mode_o = MODE_RUN;
    end
endmodule

// File: rtl/cs_rate_timer.sv
// Period timer. It counts tick pulses and raises "due" once per period.
// The period is BASE_TICKS << (max_code - code). Reserved rate values map to
// the fastest code. While held (standby), the count restarts and due stays
// set, so a pair launches as soon as the hold releases.
module cs_rate_timer #(
    parameter int BASE_TICKS = 8,
    parameter int RATE_W     = 8,
    parameter int CODE_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              hold_i,
    input  logic              launch_i,
    output logic              due_o
);
    localparam int NUM_CODES  = 1 << CODE_W;
    localparam int MAX_PERIOD = BASE_TICKS << (NUM_CODES - 1);
    localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

    logic [CODE_W-1:0] code_w;
    logic [CNT_W-1:0]  period_m1;
    logic [CNT_W-1:0]  cnt_q;
    logic              due_q;

    // Purpose: select the effective code; reserved upper bits force the fastest.
    always_comb begin
        if (|rate_i[RATE_W-1:CODE_W])
            code_w = {CODE_W{1'b1}};
        else
            code_w = rate_i[CODE_W-1:0];
    end

    // Purpose: period length minus one for the effective code.
    always_comb begin
        period_m1 = (CNT_W'(BASE_TICKS) << (CODE_W'(NUM_CODES - 1) - code_w)) - 1'b1;
    end

    // Purpose: tick counter and due flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            due_q <= 1'b1;
        end else if (hold_i) begin
            cnt_q <= '0;
            due_q <= 1'b1;
        end else begin
            if (launch_i)
                due_q <= 1'b0;
            if (tick_i) begin
                if (cnt_q >= period_m1) begin
                    cnt_q <= '0;
                    due_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign due_o = due_q;

    // R1: due is only raised by a period boundary tick or by standby hold.
    a_r1_due_from_tick : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(due_q) |-> ($past(tick_i) || $past(hold_i)));

    // R6: a hold cycle restarts the period count.
    a_r6_hold_restarts : assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold_i) |-> (cnt_q == '0 && due_q));
endmodule

// File: rtl/cs_seq.sv
// Pair sequencer. It launches local then remote conversions, waits for the
// per-channel done pulse and emits registered write strobes. It aborts
// without a write when standby is entered during a conversion. One-shot
// pairs are accepted only in software standby, and only pin standby aborts them.
// Assumes the converter answers each start with one done pulse on its channel.
module cs_seq
    import conv_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  op_mode_t          mode_i,
    input  logic              due_i,
    input  logic              oneshot_i,
    input  logic [NUM_CH-1:0] done_i,
    output logic              launch_o,
    output logic              start_o,
    output logic              chan_o,
    output logic              busy_o,
    output logic [NUM_CH-1:0] we_o
);
    seq_state_t        state_q;
    logic              os_q;
    logic              start_q;
    logic [NUM_CH-1:0] we_q;
    logic              run_w;
    logic              soft_w;
    logic              pin_w;
    logic              launch_run_w;
    logic              launch_os_w;
    logic              abort_w;

    // Purpose: decode mode and launch/abort conditions.
    always_comb begin
        run_w        = (mode_i == MODE_RUN);
        soft_w       = (mode_i == MODE_SOFT_STBY);
        pin_w        = (mode_i == MODE_PIN_STBY);
        launch_run_w = (state_q == ST_IDLE) && run_w && due_i;
        launch_os_w  = (state_q == ST_IDLE) && soft_w && oneshot_i;
        abort_w      = (state_q != ST_IDLE) && (pin_w || (soft_w && !os_q));
    end

    // Purpose: pair state machine with registered start and write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            os_q    <= 1'b0;
            start_q <= 1'b0;
            we_q    <= '0;
        end else begin
            start_q <= 1'b0;
            we_q    <= '0;
            case (state_q)
                ST_IDLE: begin
                    if (launch_run_w || launch_os_w) begin
                        state_q <= ST_LOCAL;
                        start_q <= 1'b1;
                        os_q    <= launch_os_w;
                    end
                end
                ST_LOCAL: begin
                    if (abort_w) begin
                        state_q <= ST_IDLE;
                    end else if (done_i[0]) begin
                        we_q[0] <= 1'b1;
                        state_q <= ST_REMOTE;
                        start_q <= 1'b1;
                    end
                end
                ST_REMOTE: begin
                    if (abort_w) begin
                        state_q <= ST_IDLE;
                    end else if (done_i[1]) begin
                        we_q[1] <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign launch_o = launch_run_w;
    assign start_o  = start_q;
    assign chan_o   = (state_q == ST_REMOTE);
    assign busy_o   = (state_q != ST_IDLE);
    assign we_o     = we_q;

    // R3: a start pulse only appears while a pair is in flight.
    a_r3_start_in_pair : assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> busy_o);

    // R5: never more than one value register strobe per cycle.
    a_r5_we_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_q));

    // R7: an abort leaves the block idle with no write strobe.
    a_r7_abort_no_write : assert property (@(posedge clk) disable iff (!rst_n)
        $past(abort_w) |-> (!busy_o && we_q == '0));

    // R4: busy rises only from a launch.
    a_r4_busy_from_launch : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(launch_run_w || launch_os_w));

    // R9: nothing starts after a cycle in pin standby.
    a_r9_pin_blocks_start : assert property (@(posedge clk) disable iff (!rst_n)
        $past(pin_w) |-> !start_q);
endmodule

// File: rtl/conv_sched.sv
// Conversion scheduler top. It joins the mode decode, the period timer and
// the pair sequencer. Assumes all inputs are synchronous to clk and that
// tick_i is one cycle wide.
module conv_sched #(
    parameter int BASE_TICKS = 8,
    parameter int RATE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              cfg_stop_i,
    input  logic              stby_n_i,
    input  logic              oneshot_i,
    input  logic [1:0]        conv_done_i,
    output logic              conv_start_o,
    output logic              conv_chan_o,
    output logic              busy_o,
    output logic              local_we_o,
    output logic              remote_we_o
);
    import conv_sched_pkg::*;

    op_mode_t          mode_w;
    logic              due_w;
    logic              launch_w;
    logic [NUM_CH-1:0] we_w;

    cs_mode_ctrl u_mode (
        .cfg_stop_i (cfg_stop_i),
        .stby_n_i   (stby_n_i),
        .mode_o     (mode_w)
    );

    cs_rate_timer #(
        .BASE_TICKS (BASE_TICKS),
        .RATE_W     (RATE_W),
        .CODE_W     (CODE_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .rate_i   (rate_i),
        .hold_i   (mode_w != MODE_RUN),
        .launch_i (launch_w),
        .due_o    (due_w)
    );

    cs_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_w),
        .due_i     (due_w),
        .oneshot_i (oneshot_i),
        .done_i    (conv_done_i),
        .launch_o  (launch_w),
        .start_o   (conv_start_o),
        .chan_o    (conv_chan_o),
        .busy_o    (busy_o),
        .we_o      (we_w)
    );

    assign local_we_o  = we_w[0];
    assign remote_we_o = we_w[1];
endmodule

// File: tb/conv_sched_tb_top.sv
// Directed bench for the conversion scheduler.
module conv_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BASE       = 8;
    localparam int LAT        = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] rate = 8'd7;
    logic       cfg_stop = 1'b0;
    logic       stby_n = 1'b1;
    logic       oneshot = 1'b0;
    logic [1:0] auto_done = 2'b00;
    logic [1:0] man_done = 2'b00;
    logic [1:0] conv_done;
    logic       conv_start, conv_chan, busy, local_we, remote_we;

    int n_tests = 0, n_fail = 0;
    int cyc = 0, nsl = 0, nsr = 0, nwl = 0, nwr = 0;
    int last_l_cyc = 0, last_r_cyc = 0;
    int tdiv = 0;
    bit auto_en = 1'b1;
    bit pend = 1'b0;
    int pcnt = 0;
    logic pch = 1'b0;

    assign conv_done = auto_done | man_done;

    conv_sched #(.BASE_TICKS(BASE)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .rate_i       (rate),
        .cfg_stop_i   (cfg_stop),
        .stby_n_i     (stby_n),
        .oneshot_i    (oneshot),
        .conv_done_i  (conv_done),
        .conv_start_o (conv_start),
        .conv_chan_o  (conv_chan),
        .busy_o       (busy),
        .local_we_o   (local_we),
        .remote_we_o  (remote_we)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    // Time base: one tick every TICK_DIV cycles.
    always @(negedge clk) begin
        tick <= (tdiv == TICK_DIV-1);
        tdiv <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
    end

    // Output monitor.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc = cyc + 1;
            if (conv_start) begin
                if (!conv_chan) begin nsl = nsl + 1; last_l_cyc = cyc; end
                else begin nsr = nsr + 1; last_r_cyc = cyc; end
            end
            if (local_we) nwl = nwl + 1;
            if (remote_we) nwr = nwr + 1;
        end
    end

    // Fixed-latency converter model.
    always @(negedge clk) begin
        auto_done <= 2'b00;
        if (!auto_en || !rst_n) begin
            pend <= 1'b0;
        end else if (conv_start) begin
            pend <= 1'b1; pch <= conv_chan; pcnt <= LAT;
        end else if (pend) begin
            if (pcnt == 1) begin auto_done[pch] <= 1'b1; pend <= 1'b0; end
            else pcnt <= pcnt - 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic pulse_man(input logic [1:0] d);
        man_done = d; step(); man_done = 2'b00;
    endtask

    task automatic measure(output int iv);
        int c, t0;
        c = nsl; while (nsl == c) step();
        t0 = last_l_cyc;
        c = nsl; while (nsl == c) step();
        iv = last_l_cyc - t0;
    endtask

    task automatic t_reset();
        chk("R4 reset busy", busy, 0);
        chk("R3 reset start", conv_start, 0);
        chk("R5 reset strobes", local_we | remote_we, 0);
    endtask

    task automatic t_free_run();
        rst_n = 1'b1; step();
        chk("R3 first local start", nsl, 1);
        chk("R4 busy with start", busy, 1);
        step(20);
        chk("R3 remote start", nsr, 1);
        chk("R3 order local then remote", int'(last_r_cyc > last_l_cyc), 1);
        chk("R5 local write", nwl, 1);
        chk("R5 remote write", nwr, 1);
        chk("R4 idle busy", busy, 0);
    endtask

    task automatic t_rate(input logic [7:0] r, input int exp, input string req);
        int iv;
        rate = r;
        measure(iv);
        measure(iv);
        chk(req, iv, exp);
    endtask

    task automatic t_standby_hold();
        int s, w;
        cfg_stop = 1'b1; step(20);
        s = nsl + nsr; w = nwl + nwr;
        step(300);
        chk("R6 soft standby no start", nsl + nsr, s);
        chk("R6 soft standby no write", nwl + nwr, w);
        cfg_stop = 1'b0; stby_n = 1'b0; step(300);
        chk("R6 pin standby no start", nsl + nsr, s);
    endtask

    task automatic t_oneshot_pin();
        int s;
        s = nsl + nsr;
        cfg_stop = 1'b1; oneshot = 1'b1; step(); oneshot = 1'b0; step(50);
        chk("R9 one-shot ignored, pin low, stop set", nsl + nsr, s);
        cfg_stop = 1'b0; oneshot = 1'b1; step(); oneshot = 1'b0; step(50);
        chk("R9 one-shot ignored, pin low", nsl + nsr, s);
    endtask

    task automatic t_exit_standby();
        int s;
        rate = 8'd0; s = nsl;
        stby_n = 1'b1; step();
        chk("R11 start right after standby ends", nsl, s + 1);
        step(20);
        chk("R4 idle after pair", busy, 0);
    endtask

    task automatic t_oneshot_run();
        int s;
        s = nsl + nsr;
        oneshot = 1'b1; step(); oneshot = 1'b0; step(200);
        chk("R10 one-shot ignored in run", nsl + nsr, s);
    endtask

    task automatic t_oneshot_soft();
        int sl, sr, wl, wr;
        cfg_stop = 1'b1; step(5);
        sl = nsl; sr = nsr; wl = nwl; wr = nwr;
        oneshot = 1'b1; step(); oneshot = 1'b0; step(30);
        chk("R8 one-shot local start", nsl, sl + 1);
        chk("R8 one-shot remote start", nsr, sr + 1);
        chk("R8 one-shot writes", (nwl - wl) + (nwr - wr), 2);
        chk("R8 idle after one-shot", busy, 0);
        step(200);
        chk("R8 stays in standby", nsl + nsr, sl + sr + 2);
    endtask

    task automatic t_wrong_done();
        int sl, wl, wr;
        auto_en = 1'b0; step(2);
        sl = nsl; wl = nwl; wr = nwr;
        cfg_stop = 1'b0; step();
        chk("R11 launch on leaving soft standby", nsl, sl + 1);
        pulse_man(2'b10);
        chk("R5 wrong-channel done ignored", nwl, wl);
        chk("R4 busy held while waiting", busy, 1);
        pulse_man(2'b01);
        chk("R5 local write after local done", nwl, wl + 1);
        chk("R3 remote start follows local done", int'(conv_chan), 1);
        pulse_man(2'b01);
        chk("R5 local done ignored in remote", nwr, wr);
    endtask

    task automatic t_abort_soft();
        int wr;
        wr = nwr;
        cfg_stop = 1'b1; step();
        chk("R7 busy drops on soft standby", busy, 0);
        pulse_man(2'b10); step(2);
        chk("R7 late done not written", nwr, wr);
    endtask

    task automatic t_abort_pin_same();
        int wl;
        cfg_stop = 1'b0; step();
        wl = nwl;
        chk("R3 start before pin abort", busy, 1);
        man_done = 2'b01; stby_n = 1'b0; step(); man_done = 2'b00;
        chk("R7 busy drops on pin standby", busy, 0);
        step(3);
        chk("R7 same-cycle done not written", nwl, wl);
    endtask

    task automatic t_oneshot_abort();
        int sl, wl, s;
        stby_n = 1'b1; cfg_stop = 1'b1; step(3);
        sl = nsl; wl = nwl;
        oneshot = 1'b1; step(); oneshot = 1'b0;
        chk("R8 one-shot started", nsl, sl + 1);
        stby_n = 1'b0; step();
        chk("R12 busy drops on pin low", busy, 0);
        pulse_man(2'b01); step(2);
        chk("R12 aborted one-shot not written", nwl, wl);
        s = nsl + nsr;
        stby_n = 1'b1; step(50);
        chk("R12 stays in soft standby", nsl + nsr, s);
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        step(5);
        t_reset();
        t_free_run();
        t_rate(8'd7, 32 << 0, "R1 code 7 period");
        t_rate(8'd5, 32 << 2, "R1 code 5 period");
        t_rate(8'd0, 32 << 7, "R1 code 0 period");
        t_rate(8'h38, 32, "R2 reserved 0x38 as code 7");
        t_rate(8'h82, 32, "R2 reserved 0x82 as code 7");
        t_standby_hold();
        t_oneshot_pin();
        t_exit_standby();
        t_oneshot_run();
        t_oneshot_soft();
        t_wrong_done();
        t_abort_soft();
        t_abort_pin_same();
        t_oneshot_abort();
        summary();
        $finish;
    end
endmodule